// File: doc/BRIEF.md
# Quantized-Level Refresh Controller

This block keeps the stored template words of a learning classifier array close to stable quantised levels. Storage itself lies outside the block. The controller visits the cells one at a time in the background and reads the selected word on a combinational read port. For each cell it runs a single-slope conversion: a reference staircase climbs one level per cycle from the bottom. In the first cycle that the stored word is below the reference, the parity of the current staircase step is captured. That parity sets the direction of a one-unit correction, which is written back to the cell.

Each stored word holds a 7-bit level with 2 fractional bits below it, so one correction unit is a quarter of a level. A cell whose level is odd is nudged up, and a cell whose level is even is nudged down. Every cell therefore settles around an even level boundary and stays there, even though its storage drifts.

A global learn select hands the same write path to the learning unit. While it is high, the selected cell is stepped one unit toward an external input, and refresh waits. When learning releases, refresh converts the interrupted cell again from the bottom of the staircase.

Top module: `refresh_top`

## Requirements
- R1: While reset (active low, asynchronous) is asserted and in the first cycle after it, `updEn` is 0, `cellAddr` is 0, and the staircase starts at step 0.
- R2: In refresh mode, cells are converted one after another in row-major flat order 0,1,…,CELLS-1 and then back to 0, one cell per conversion. `cellAddr` shows the cell being converted.
- R3: The staircase reference in word units is step×4, with the step running 0..127 and rising by one each refresh cycle of a conversion. A crossing is the first cycle in which `cellValue` < step×4.
- R4: At a crossing, if the step is odd the cell is written with `cellValue`−1, and if it is even with `cellValue`+1. `updEn`, `updAddr` and `updData` show the write in the next cycle. Conversion of the next cell starts in that same next cycle at step 0.
- R5: If no crossing has happened by step 127 (a stored level of 127), no write is issued and the next cell starts at step 0 in the following cycle.
- R6: A downward refresh correction of a cell holding 0 is suppressed (no write).
- R7: While `learnEn` is high, `cellAddr` equals `learnAddr`. In the next cycle the cell is written one unit toward `learnInput` (+1 if the input is larger, −1 if it is smaller), and no write is issued if the two are equal.
- R8: Every cycle with `learnEn` high pauses refresh. In the first refresh cycle afterwards, the same cell is converted again from step 0.
- R9: Words are 9 bits: bits 8..2 hold the level and bits 1..0 the fraction. One correction unit is 1 LSB, a quarter of a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| learnEn | input | 1 | Hands the update path to learning for this cycle |
| learnAddr | input | 4 | Flat cell index chosen by the learning unit |
| learnInput | input | 9 | Input value that the learned cell moves toward |
| cellValue | input | 9 | Stored word of the cell at `cellAddr` (combinational read) |
| cellAddr | output | 4 | Flat index of the cell being read |
| updEn | output | 1 | Write strobe for one correction |
| updAddr | output | 4 | Cell index of the write |
| updData | output | 9 | New word to store |

## Verification
A refresh correction for a cell at level L is due exactly L+2 cycles after its conversion begins. A cell at level 127 gives no write, and its successor starts 128 cycles after it began. A learning correction is due one cycle after the learn cycle. The bench keeps a one-deep expectation that it computes from the requirements at each falling edge. It compares that expectation with the outputs at the next falling edge, so every write, and every cycle without a write, is checked in the exact cycle it is due. Words 0 to 511 are swept across the cells in batches, with learn bursts of several lengths placed among the conversions.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic learnCyc;  // learning owns the update path this cycle
    logic rampHit;   // staircase crossed the stored word this cycle
    logic rampEnd;   // staircase reached full scale without crossing
    logic stepOdd;   // parity of the current staircase step
  } refresh_strobe_t;

endpackage

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_pkg::*;
#(
  parameter int ROWS    = 4,
  parameter int COLS    = 4,
  parameter int LEVEL_W = 7,
  parameter int ADDR_W  = $clog2(ROWS * COLS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                learnEn,
  input  logic [ADDR_W-1:0]   learnAddr,
  input  logic                crossed,
  output logic [LEVEL_W-1:0]  step,
  output logic [ADDR_W-1:0]   cellAddr,
  output refresh_strobe_t     strobe
);

  localparam int CELLS = ROWS * COLS;
  localparam logic [LEVEL_W-1:0] STEP_MAX  = LEVEL_W'((1 << LEVEL_W) - 1);
  localparam logic [ADDR_W-1:0]  LAST_CELL = ADDR_W'(CELLS - 1);

  logic [ADDR_W-1:0] refAddr;

  always_comb begin
    strobe.learnCyc = learnEn;
    strobe.rampHit  = !learnEn && crossed;
    strobe.rampEnd  = !learnEn && !crossed && (step == STEP_MAX);
    strobe.stepOdd  = step[0];
    cellAddr        = learnEn ? learnAddr : refAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step    <= '0;
      refAddr <= '0;
    end else if (strobe.learnCyc) begin
      step <= '0;  // restart the interrupted cell
    end else if (strobe.rampHit || strobe.rampEnd) begin
      step    <= '0;
      refAddr <= (refAddr == LAST_CELL) ? '0 : refAddr + ADDR_W'(1);
    end else begin
      step <= step + LEVEL_W'(1);
    end
  end

endmodule

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_pkg::*;
#(
  parameter int LEVEL_W = 7,
  parameter int FRAC_W  = 2,
  parameter int ADDR_W  = 4,
  parameter int WORD_W  = LEVEL_W + FRAC_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  refresh_strobe_t     strobe,
  input  logic [LEVEL_W-1:0]  step,
  input  logic [ADDR_W-1:0]   cellAddr,
  input  logic [WORD_W-1:0]   cellValue,
  input  logic [WORD_W-1:0]   learnInput,
  output logic                crossed,
  output logic                updEn,
  output logic [ADDR_W-1:0]   updAddr,
  output logic [WORD_W-1:0]   updData
);

  logic [WORD_W-1:0] refWord;
  logic [WORD_W-1:0] valUp;
  logic [WORD_W-1:0] valDown;

  always_comb begin
    refWord = {step, {FRAC_W{1'b0}}};
    crossed = cellValue < refWord;
    valUp   = cellValue + WORD_W'(1);
    valDown = cellValue - WORD_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updEn   <= 1'b0;
      updAddr <= '0;
      updData <= '0;
    end else begin
      updAddr <= cellAddr;
      if (strobe.learnCyc) begin
        updEn   <= (learnInput != cellValue);
        updData <= (learnInput > cellValue) ? valUp : valDown;
      end else if (strobe.rampHit) begin
        updEn   <= !(strobe.stepOdd && (cellValue == '0));
        updData <= strobe.stepOdd ? valDown : valUp;
      end else begin
        updEn   <= 1'b0;
        updData <= cellValue;
      end
    end
  end

endmodule

// File: rtl/refresh_top.sv
module refresh_top
  import refresh_pkg::*;
#(
  parameter int ROWS    = 4,
  parameter int COLS    = 4,
  parameter int LEVEL_W = 7,
  parameter int FRAC_W  = 2,
  parameter int ADDR_W  = $clog2(ROWS * COLS),
  parameter int WORD_W  = LEVEL_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               learnEn,
  input  logic [ADDR_W-1:0]  learnAddr,
  input  logic [WORD_W-1:0]  learnInput,
  input  logic [WORD_W-1:0]  cellValue,
  output logic [ADDR_W-1:0]  cellAddr,
  output logic               updEn,
  output logic [ADDR_W-1:0]  updAddr,
  output logic [WORD_W-1:0]  updData
);

  refresh_strobe_t    strobe;
  logic [LEVEL_W-1:0] step;
  logic               crossed;

  refresh_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .LEVEL_W(LEVEL_W), .ADDR_W(ADDR_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .learnEn(learnEn), .learnAddr(learnAddr),
    .crossed(crossed), .step(step), .cellAddr(cellAddr), .strobe(strobe)
  );

  refresh_dp #(
    .LEVEL_W(LEVEL_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .step(step),
    .cellAddr(cellAddr), .cellValue(cellValue), .learnInput(learnInput),
    .crossed(crossed), .updEn(updEn), .updAddr(updAddr), .updData(updData)
  );

endmodule

// File: rtl/refresh_checker.sv
module refresh_checker #(
  parameter int ROWS    = 4,
  parameter int COLS    = 4,
  parameter int FRAC_W  = 2,
  parameter int ADDR_W  = 4,
  parameter int WORD_W  = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic               learnEn,
  input logic [ADDR_W-1:0]  learnAddr,
  input logic [WORD_W-1:0]  learnInput,
  input logic [WORD_W-1:0]  cellValue,
  input logic [ADDR_W-1:0]  cellAddr,
  input logic               updEn,
  input logic [ADDR_W-1:0]  updAddr,
  input logic [WORD_W-1:0]  updData
);

  localparam logic [ADDR_W-1:0] LAST_CELL = ADDR_W'(ROWS * COLS - 1);

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    updEn |-> ((updData == $past(cellValue) + WORD_W'(1)) ||
               (updData == $past(cellValue) - WORD_W'(1)))); // R9

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    updEn |-> !(($past(cellValue) == '0) && (updData == '1))); // R6

  AST_REFRESH_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (updEn && !$past(learnEn)) |->
      ((updData > $past(cellValue)) == $past(cellValue[FRAC_W]))); // R4

  AST_LEARN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    learnEn |=> ((updEn == ($past(learnInput) != $past(cellValue))) &&
                 (updAddr == $past(learnAddr)))); // R7

  AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (!learnEn && !$past(learnEn) && (cellAddr != $past(cellAddr))) |->
      (cellAddr == (($past(cellAddr) == LAST_CELL) ? '0
                    : $past(cellAddr) + ADDR_W'(1)))); // R2

endmodule

bind refresh_top refresh_checker #(
  .ROWS(ROWS), .COLS(COLS), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) i_chk (.*);

// File: tb/test_refresh_top.sv
module test_refresh_top;

  localparam int CELLS  = 16;
  localparam int ADDR_W = 4;
  localparam int WORD_W = 9;
  localparam int WD_LIMIT = 190000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              learnEn = 1'b0;
  logic [ADDR_W-1:0] learnAddr = '0;
  logic [WORD_W-1:0] learnInput = '0;
  logic [WORD_W-1:0] cellValue;
  logic [ADDR_W-1:0] cellAddr;
  logic              updEn;
  logic [ADDR_W-1:0] updAddr;
  logic [WORD_W-1:0] updData;

  logic [WORD_W-1:0] mem [CELLS];

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  // expectation model
  int    kM = 0;
  int    aM = 0;
  int    visits = 0;
  bit    pEn = 0;
  int    pAddr = 0;
  int    pData = 0;
  string pReq = "R1";

  always #4 clk = ~clk;  // 125 MHz

  refresh_top i_refresh_top (
    .clk(clk), .rstN(rstN), .learnEn(learnEn), .learnAddr(learnAddr),
    .learnInput(learnInput), .cellValue(cellValue), .cellAddr(cellAddr),
    .updEn(updEn), .updAddr(updAddr), .updData(updData)
  );

  assign cellValue = mem[cellAddr];

  always @(posedge clk) begin
    if (rstN && updEn) mem[updAddr] <= updData;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int v;
    if (!rstN) begin
      kM = 0; aM = 0; pEn = 0; pReq = "R1";
      check(updEn == 1'b0, "R1", "updEn in reset", updEn, 0);
      check(cellAddr == '0, "R1", "cellAddr in reset", cellAddr, 0);
    end else begin
      check(updEn == pEn, pReq, "updEn", updEn, pEn);
      if (pEn && updEn) begin
        check(updAddr == pAddr, pReq, "updAddr", updAddr, pAddr);
        check(updData == pData, pReq, "updData", updData, pData);
      end
      if (learnEn) begin
        check(cellAddr == learnAddr, "R7", "cellAddr while learning", cellAddr, learnAddr);
        v = mem[learnAddr];
        pEn = (learnInput != v);
        pAddr = learnAddr;
        pData = (learnInput > v) ? v + 1 : v - 1;
        pReq = "R7";
        kM = 0;  // R8: conversion restarts afterwards
      end else begin
        check(cellAddr == aM, "R2", "cellAddr refresh order (R8 resume)", cellAddr, aM);
        v = mem[aM];
        if (v < kM * 4) begin
          if ((kM % 2 == 1) && v == 0) begin
            pEn = 0; pReq = "R6";
          end else begin
            pEn = 1; pAddr = aM;
            pData = (kM % 2 == 1) ? v - 1 : v + 1;
            pReq = "R4";
          end
          kM = 0; aM = (aM + 1) % CELLS; visits++;
        end else if (kM == 127) begin
          pEn = 0; pReq = "R5";
          kM = 0; aM = (aM + 1) % CELLS; visits++;
        end else begin
          pEn = 0; pReq = "R3";
          kM++;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WD_LIMIT) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic doReset();
    @(posedge clk); #1;
    rstN = 1'b0; learnEn = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    visits = 0;
  endtask

  initial begin
    // R9 sweep: every 9-bit word 0..511 placed in a cell and refreshed once
    for (int b = 0; b < 32; b++) begin
      @(posedge clk); #1;
      rstN = 1'b0;
      for (int i = 0; i < CELLS; i++) mem[i] = WORD_W'(b * 16 + i);
      doReset();
      while (visits < CELLS) @(posedge clk);
    end

    // learn bursts among conversions (R7, R8)
    @(posedge clk); #1;
    rstN = 1'b0;
    for (int i = 0; i < CELLS; i++) mem[i] = WORD_W'((i * 37 + 11) % 512);
    doReset();
    for (int n = 0; n < 40; n++) begin
      repeat (20 + (n % 9) * 13) @(posedge clk);
      #1;
      learnEn = 1'b1;
      learnAddr = ADDR_W'((n * 5 + 3) % CELLS);
      learnInput = (n % 4 == 0) ? mem[(n * 5 + 3) % CELLS] : WORD_W'((n * 97) % 512);
      repeat (n % 3) begin
        @(posedge clk); #1;
        if (n % 6 == 1) learnAddr = ADDR_W'(n % CELLS);
      end
      @(posedge clk); #1;
      learnEn = 1'b0;
    end
    visits = 0;
    while (visits < 2 * CELLS) @(posedge clk);
    @(negedge clk);
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule